// File: doc/BRIEF.md
# Double-Buffered PWM Channel Bank

This block turns the low byte of a free-running counter into one pulse-width modulated output per channel. The counter and its prescaler sit outside the block, and every channel watches the same counter value. All channels therefore run at one common frequency. Each channel holds its own duty value, so the duty cycles are independent.

A channel compares the counter against a 9-bit active duty word. The output is low while the counter is below that word and high once the counter reaches it. Software writes a 9-bit shadow word. The shadow word becomes active only when the counter wraps from its all-ones value to zero. A duty change therefore always begins on a period boundary and never cuts a period short or stretches it. The top bit of the duty word sits above every counter value. Setting it holds the output low for the whole period.

The shadow write port is a plain strobe with no back-pressure. The block accepts a write in every cycle, and the most recent write before a wrap is the one that takes effect.

Top module: `pwm_bank`

## Requirements
- R1: After reset every output is low and both the shadow and the active duty word of every channel are zero. An enabled channel that has not been written therefore drives high.
- R2: While enabled, `pwm_out[i]` one clock after a counter sample equals 1 exactly when the zero-extended counter value is greater than or equal to the channel's 9-bit active duty word.
- R3: A write strobe `duty_we[i]` loads `duty_wdata[9*i+8 : 9*i]` into channel i's shadow word. Bit 8 of the slice is the extension bit and bits 7:0 are the compare byte.
- R4: The active word takes the shadow word only on the clock where the counter reads 0 and the previous sampled counter value was 255. At all other times it holds, so a shadow write in mid-period leaves the current period unchanged.
- R5: A shadow write in the same clock as a wrap does not reach the active word at that wrap. It is applied at the next wrap.
- R6: A channel drives PWM only when both `pwm_en[i]` and `cmp_en[i]` are 1. Otherwise its output is 0 one clock later.
- R7: An active word with the extension bit set keeps the enabled output low for the entire period.
- R8: An active word of 0 keeps the enabled output high for the entire period.
- R9: All channels share one counter, and each channel's duty word is separate from the others. A write to one channel does not change another channel's output.
- R10: When the counter holds a value for several clocks because of an outside prescaler, one wrap causes exactly one reload. Shadow writes made while 0 is held after the wrap wait for the following wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_lo | input | 8 | Low byte of the shared counter |
| pwm_en | input | NUM_CH | Per-channel PWM mode bit |
| cmp_en | input | NUM_CH | Per-channel comparator enable bit |
| duty_we | input | NUM_CH | Per-channel shadow write strobe |
| duty_wdata | input | 9*NUM_CH | Shadow duty words, 9 bits per channel |
| pwm_out | output | NUM_CH | PWM outputs, registered |

## Verification
A corrupted active word shows up within one clock as an output edge at the wrong counter value. A missed or extra reload shows up only at the period boundary, where the whole following period runs with the wrong duty. The stimulus therefore always places writes mid-period and at the wrap, then runs complete periods after them. A broken wrap detector becomes visible when the counter is held for several clocks: a second reload at a held zero would pull in a write one period too early.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int CNT_W  = 8;
  localparam int DUTY_W = CNT_W + 1;

  typedef struct packed {
    logic             ext;
    logic [CNT_W-1:0] cmp;
  } duty_t;
endpackage

// File: rtl/pwm_wrap_detect.sv
module pwm_wrap_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cnt;
  end

  // Only the one clock where the count moves from all-ones to zero.
  assign wrap = (prev_q == TOP) && (cnt == '0);
endmodule

// File: rtl/pwm_duty_buffer.sv
module pwm_duty_buffer
  import pwm_bank_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  duty_t wr_duty,
  input  logic  wrap,
  output duty_t shadow,
  output duty_t active,
  output duty_t active_eff
);
  // At a wrap the compare already uses the word being loaded.
  assign active_eff = wrap ? shadow : active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= '0;
    end else begin
      active <= active_eff;
      if (wr_en) shadow <= wr_duty;
    end
  end
endmodule

// File: rtl/pwm_compare_out.sv
module pwm_compare_out
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] cnt,
  input  duty_t            duty,
  output logic             out
);
  logic at_or_above;

  assign at_or_above = {1'b0, cnt} >= {duty.ext, duty.cmp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out <= 1'b0;
    else        out <= enable && at_or_above;
  end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CNT_W-1:0]         cnt_lo,
  input  logic [NUM_CH-1:0]        pwm_en,
  input  logic [NUM_CH-1:0]        cmp_en,
  input  logic [NUM_CH-1:0]        duty_we,
  input  logic [NUM_CH*DUTY_W-1:0] duty_wdata,
  output logic [NUM_CH-1:0]        pwm_out
);
  logic                     wrap;
  logic [NUM_CH*DUTY_W-1:0] shadow_flat;
  logic [NUM_CH*DUTY_W-1:0] active_flat;

  pwm_wrap_detect #(.W(CNT_W)) u_wrap (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (cnt_lo),
    .wrap  (wrap)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    duty_t sh, ac, eff;

    pwm_duty_buffer u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (duty_we[ch]),
      .wr_duty    (duty_t'(duty_wdata[ch*DUTY_W +: DUTY_W])),
      .wrap       (wrap),
      .shadow     (sh),
      .active     (ac),
      .active_eff (eff)
    );

    pwm_compare_out u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (pwm_en[ch] && cmp_en[ch]),
      .cnt    (cnt_lo),
      .duty   (eff),
      .out    (pwm_out[ch])
    );

    assign shadow_flat[ch*DUTY_W +: DUTY_W] = sh;
    assign active_flat[ch*DUTY_W +: DUTY_W] = ac;
  end
endmodule

// File: rtl/pwm_bank_checker.sv
module pwm_bank_checker #(
  parameter int NUM_CH = 2,
  parameter int CW     = 8,
  parameter int DW     = 9
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [CW-1:0]        cnt_lo,
  input logic [NUM_CH-1:0]    pwm_en,
  input logic [NUM_CH-1:0]    cmp_en,
  input logic [NUM_CH-1:0]    duty_we,
  input logic [NUM_CH*DW-1:0] duty_wdata,
  input logic [NUM_CH-1:0]    pwm_out,
  input logic                 wrap,
  input logic [NUM_CH*DW-1:0] shadow_flat,
  input logic [NUM_CH*DW-1:0] active_flat
);
  // R10: a held count can never look like a wrap
  assert_held_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cnt_lo) |-> !wrap);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    assert_disabled_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwm_en[ch] && cmp_en[ch]) |=> !pwm_out[ch]);

    assert_zero_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_en[ch] && cmp_en[ch] && !wrap && active_flat[ch*DW +: DW] == '0)
      |=> pwm_out[ch]);

    assert_ext_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_en[ch] && cmp_en[ch] && !wrap && active_flat[ch*DW + DW - 1])
      |=> !pwm_out[ch]);

    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> active_flat[ch*DW +: DW] == $past(shadow_flat[ch*DW +: DW]));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(active_flat[ch*DW +: DW]));

    assert_shadow_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      duty_we[ch] |=> shadow_flat[ch*DW +: DW] == $past(duty_wdata[ch*DW +: DW]));
  end
endmodule

bind pwm_bank pwm_bank_checker #(
  .NUM_CH (NUM_CH),
  .CW     (pwm_bank_pkg::CNT_W),
  .DW     (pwm_bank_pkg::DUTY_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cnt_lo      (cnt_lo),
  .pwm_en      (pwm_en),
  .cmp_en      (cmp_en),
  .duty_we     (duty_we),
  .duty_wdata  (duty_wdata),
  .pwm_out     (pwm_out),
  .wrap        (wrap),
  .shadow_flat (shadow_flat),
  .active_flat (active_flat)
);

// File: tb/tb_pwm_bank.sv
module tb_pwm_bank;
  localparam int NCH = 2;
  localparam int DW  = 9;

  typedef struct packed {
    logic [8:0] d0;
    logic [8:0] d1;
    logic [1:0] pe;
    logic [1:0] ce;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{9'h080, 9'h040, 2'b11, 2'b11},
    '{9'h000, 9'h100, 2'b11, 2'b11},
    '{9'h0FF, 9'h001, 2'b11, 2'b11},
    '{9'h1FF, 9'h000, 2'b11, 2'b11},
    '{9'h080, 9'h080, 2'b01, 2'b11},
    '{9'h080, 9'h080, 2'b11, 2'b10},
    '{9'h0C0, 9'h020, 2'b11, 2'b11},
    '{9'h001, 9'h0FE, 2'b11, 2'b11}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [7:0]       cnt_lo = '0;
  logic [NCH-1:0]   pwm_en = '0, cmp_en = '0, duty_we = '0;
  logic [NCH*DW-1:0] duty_wdata = '0;
  logic [NCH-1:0]   pwm_out;

  int checks = 0, fails = 0;
  string cur_tag = "R1";
  logic [NCH-1:0] want_pe = '0, want_ce = '0;

  logic [8:0]     m_sh [NCH];
  logic [8:0]     m_ac [NCH];
  logic [7:0]     m_prev;
  logic [NCH-1:0] exp_out;
  logic           have_exp = 1'b0;

  pwm_bank #(.NUM_CH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_lo(cnt_lo), .pwm_en(pwm_en), .cmp_en(cmp_en),
    .duty_we(duty_we), .duty_wdata(duty_wdata), .pwm_out(pwm_out)
  );

  always #2.5 clk = ~clk;

  initial begin
    #(2_000_000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  // One clock: check the result of the previous drive, then drive and predict.
  task automatic step(input logic [7:0] c, input logic [NCH-1:0] we, input logic [NCH*DW-1:0] wd);
    logic       wr;
    logic [8:0] eff;
    @(negedge clk);
    if (have_exp) begin
      for (int ch = 0; ch < NCH; ch++) begin
        checks++;
        if (pwm_out[ch] !== exp_out[ch]) begin
          fails++;
          $display("FAIL %s ch%0d cnt_prev=%0d actual=%b expected=%b",
                   cur_tag, ch, m_prev, pwm_out[ch], exp_out[ch]);
        end
      end
    end
    pwm_en = want_pe; cmp_en = want_ce;
    cnt_lo = c; duty_we = we; duty_wdata = wd;
    wr = (m_prev == 8'hFF) && (c == 8'h00);
    for (int ch = 0; ch < NCH; ch++) begin
      eff = wr ? m_sh[ch] : m_ac[ch];
      exp_out[ch] = want_pe[ch] && want_ce[ch] && ({1'b0, c} >= eff);
      m_ac[ch] = eff;
      if (we[ch]) m_sh[ch] = wd[ch*DW +: DW];
    end
    m_prev = c;
    have_exp = 1'b1;
  endtask

  // One full counter period; each value held 'hold' clocks, write at step index wr_idx.
  task automatic run_period(input int hold, input int wr_idx, input logic [NCH-1:0] wmask,
                            input logic [NCH*DW-1:0] wd);
    int idx = 0;
    for (int c = 0; c < 256; c++) begin
      for (int h = 0; h < hold; h++) begin
        step(8'(c), (idx == wr_idx) ? wmask : '0, wd);
        idx++;
      end
    end
  endtask

  initial begin
    for (int ch = 0; ch < NCH; ch++) begin m_sh[ch] = '0; m_ac[ch] = '0; end
    m_prev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: output low out of reset
    checks++;
    if (pwm_out !== '0) begin
      fails++;
      $display("FAIL R1 reset output actual=%b expected=00", pwm_out);
    end

    // R1: unwritten enabled channels see zero duty words -> constantly high
    cur_tag = "R1";
    want_pe = '1; want_ce = '1;
    run_period(1, -1, '0, '0);
    run_period(1, -1, '0, '0);

    // Table: write mid-period (R4 no effect yet), then a full period with new duty.
    // R3 encoding: bit 8 extension, 7:0 compare; R9 channels carry different words.
    for (int v = 0; v < NV; v++) begin
      if (VECS[v].pe != 2'b11 || VECS[v].ce != 2'b11) cur_tag = "R6";
      else if (VECS[v].d0[8] || VECS[v].d1[8])      cur_tag = "R7";
      else if (VECS[v].d0 == 0 || VECS[v].d1 == 0)  cur_tag = "R8";
      else if (v == 6)                              cur_tag = "R9";
      else                                          cur_tag = "R2";
      want_pe = VECS[v].pe; want_ce = VECS[v].ce;
      run_period(1, 128, 2'b11, {VECS[v].d1, VECS[v].d0});
      run_period(1, -1, '0, '0);
    end

    // R4 / R9: write only channel 1 mid-period; channel 0 must not move.
    cur_tag = "R4";
    want_pe = '1; want_ce = '1;
    run_period(1, 40, 2'b10, {9'h030, 9'h1AA});
    run_period(1, -1, '0, '0);

    // R5: write landing exactly on the wrap clock waits one more period.
    cur_tag = "R5";
    run_period(1, 0, 2'b11, {9'h0E0, 9'h010});
    run_period(1, -1, '0, '0);

    // R10: counter held three clocks per value; write on the second clock of 00.
    cur_tag = "R10";
    run_period(3, 1, 2'b11, {9'h060, 9'h0A0});
    run_period(3, -1, '0, '0);

    step(8'h00, '0, '0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule